// File: doc/BRIEF.md
# Host Control and Status Register Interface

This block sits between a host processor and the rest of a serial-bus remote terminal. It decodes host accesses from four strobes: an active-low chip select, an active-low register-control select, a read/write line (1 = read) and address bit 0. From these it produces three actions. One writes an 8-bit control register. Another writes to the alternate address and fires a master reset. The third drives a 16-bit system status word onto the host read bus.

The control register's bits are brought out as individual enables and flags for the channel receivers, the self-test logic and the outgoing status word. The status-word flags are also snapshotted whenever the terminal signals a new command. This means a host write becomes part of the next reply only if it lands before that command strobe. The system word reports three fields, each captured from the command-recognition logic: the last command's 5-bit mode-code or subaddress field, whether that field was a subaddress, and which channel carried the command.

All registers sample on the rising clock edge. Reset is synchronous and active low. The read path is combinational from the strobes.

Top module: `hreg_if`

## Requirements
- R1: A clock edge that samples host_cs_n=0, host_ctl_n=0, host_rd_wr=0 and host_a0=0 loads host_wdata into the control register, and the new value is visible on the control outputs after that edge.
- R2: Control register bit positions are fixed: bit 0 ch_a_en, bit 1 ch_b_en, bit 2 term_flag, bit 3 sys_busy, bit 4 subsys_busy, bit 5 selftest_sel_a (1 selects channel A), bit 6 selftest_en, bit 7 svc_req.
- R3: An access with host_cs_n=1 or host_ctl_n=1 changes no register, raises no reset pulse and leaves host_rdata_oe at 0.
- R4: A write (host_cs_n=0, host_ctl_n=0, host_rd_wr=0) with host_a0=1 raises master_rst_pulse for exactly the one cycle after the first edge that samples it. Holding the access for more cycles gives no further pulse until the access has been released for at least one edge.
- R5: On the edge that raises master_rst_pulse, the control register and stword_flags return to 0 and the system word returns to its reset value. This takes priority over a same-edge cmd_capture, and host_wdata is ignored.
- R6: While host_cs_n=0, host_ctl_n=0, host_rd_wr=1 and host_a0=0, host_rdata_oe is 1 and host_rdata carries the system word in the same cycle. Otherwise host_rdata_oe is 0 and host_rdata is 0.
- R7: System word layout: bits 4..0 are the last command field, bit 5 is 1 for a subaddress command and 0 for a mode code, bit 6 is 1 for channel A and 0 for channel B, and bits 15..7 read 0.
- R8: An edge that samples cmd_capture=1 stores cmd_field, cmd_is_subaddr and cmd_on_a into the system word. With cmd_capture=0 the system word holds.
- R9: After rst_n is held low for an edge, all control outputs, stword_flags and master_rst_pulse are 0, and the system word reads 0x0040.
- R10: An edge that samples cmd_capture=1 copies control bits {svc_req, subsys_busy, sys_busy, term_flag} into stword_flags[3:0] (term_flag at bit 0, sys_busy at bit 1, subsys_busy at bit 2, svc_req at bit 3) as they stood before that edge. A control write sampled on the same edge is therefore not included, and one sampled on an earlier edge is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ctl_n | input | 1 | Host register-control select, active low |
| host_rd_wr | input | 1 | 1 = read, 0 = write |
| host_a0 | input | 1 | Host address bit 0 |
| host_wdata | input | 8 | Host write data (low data byte) |
| host_rdata | output | 16 | System word read data, 0 when not reading |
| host_rdata_oe | output | 1 | Read data bus driver enable |
| cmd_capture | input | 1 | New command recognised, capture status |
| cmd_field | input | 5 | Mode code or subaddress of the command |
| cmd_is_subaddr | input | 1 | 1 = subaddress command, 0 = mode code |
| cmd_on_a | input | 1 | 1 = command arrived on channel A |
| master_rst_pulse | output | 1 | One-cycle master reset request |
| ch_a_en | output | 1 | Channel A receiver enable |
| ch_b_en | output | 1 | Channel B receiver enable |
| term_flag | output | 1 | Terminal flag |
| sys_busy | output | 1 | System busy |
| subsys_busy | output | 1 | Subsystem busy |
| selftest_sel_a | output | 1 | Self-test channel select, 1 = A |
| selftest_en | output | 1 | Self-test enable |
| svc_req | output | 1 | Service request |
| stword_flags | output | 4 | Status-word flags snapshotted at command capture |

## Verification
The bench sweeps all sixteen combinations of the four strobes with varied data. A decoder that ignored one strobe would let a transparent memory access corrupt the control register or enable the read driver. A held reset write probes pulse stretching: an edge-blind decoder would pulse on every cycle. The bench also sets a command capture on the reset edge, and a design with the wrong priority would leave captured status behind after the reset. A control write on the same edge as a capture, compared with one a cycle earlier, separates a snapshot taken from the old register from one that reads the incoming data. The bench walks all 256 control values and all 128 status captures to expose swapped bit positions.

// File: rtl/hreg_pkg.sv
// Shared types for the host register interface.
// Assumes the control register layout is fixed at eight bits.
package hreg_pkg;
    // Control register, MSB first so bit 0 is the channel A enable.
    typedef struct packed {
        logic svc_req;
        logic st_en;
        logic st_sel_a;
        logic subsys_busy;
        logic sys_busy;
        logic term_flag;
        logic chb_en;
        logic cha_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLAG_W = 4;
endpackage

// File: rtl/hreg_decode.sv
// Decodes host strobes into control write, reset write and status read.
// Raises a one-cycle master reset on the first sampled edge of a reset write.
// Assumes host strobes are synchronous to clk.
module hreg_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ctl_n,
    input  logic rd_wr,
    input  logic a0,
    output logic wr_ctrl,
    output logic rd_sys,
    output logic clr,
    output logic mrst_pulse
);
    logic wr_any;
    logic wr_rst;
    logic rst_seen_q;

    // Access classification from the strobes.
    always_comb begin
        wr_any  = !cs_n && !ctl_n && !rd_wr;
        wr_ctrl = wr_any && !a0;
        wr_rst  = wr_any && a0;
        rd_sys  = !cs_n && !ctl_n && rd_wr && !a0;
        clr     = wr_rst && !rst_seen_q;
    end

    // Track a held reset write and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen_q <= 1'b0;
            mrst_pulse <= 1'b0;
        end else begin
            rst_seen_q <= wr_rst;
            mrst_pulse <= clr;
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_pulse |=> !mrst_pulse);
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_pulse |-> $past(wr_rst));
    a_r3_no_pulse_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || ctl_n) |=> !mrst_pulse);
endmodule

// File: rtl/hreg_ctrl.sv
// Holds the control register and the status-word flag snapshot.
// The snapshot is taken from the register value before the capture edge.
module hreg_ctrl
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              clr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              cap,
    output ctrl_t             q,
    output logic [FLAG_W-1:0] snap
);
    // Control register load and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (wr) begin
            q <= ctrl_t'(wdata);
        end
    end

    // Status-word flag snapshot on command capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            snap <= '0;
        end else if (cap) begin
            snap <= {q.svc_req, q.subsys_busy, q.sys_busy, q.term_flag};
        end
    end

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (q == $past(wdata)));
    a_r5_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0 && snap == '0));
    a_r10_snap_old: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr) |=> (snap[0] == $past(q.term_flag) && snap[3] == $past(q.svc_req)));
endmodule

// File: rtl/hreg_sys.sv
// System status word: last command field, its type and arrival channel.
// Drives the word on reads only; unused upper bits read as zero.
module hreg_sys #(
    parameter int FIELD_W = 5,
    parameter int SYS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               upd,
    input  logic [FIELD_W-1:0] field,
    input  logic               is_sa,
    input  logic               on_a,
    input  logic               rd,
    output logic [SYS_W-1:0]   rdata,
    output logic               oe
);
    localparam int USED = FIELD_W + 2;

    logic [FIELD_W-1:0] field_q;
    logic               sa_q;
    logic               a_q;
    logic [SYS_W-1:0]   word;

    // Capture status from command recognition.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            field_q <= '0;
            sa_q    <= 1'b0;
            a_q     <= 1'b1;
        end else if (upd) begin
            field_q <= field;
            sa_q    <= is_sa;
            a_q     <= on_a;
        end
    end

    assign word[FIELD_W-1:0] = field_q;
    assign word[FIELD_W]     = sa_q;
    assign word[FIELD_W+1]   = a_q;

    generate
        if (SYS_W > USED) begin : g_pad
            assign word[SYS_W-1:USED] = '0;
        end
    endgenerate

    // Read bus gating.
    always_comb begin
        oe    = rd;
        rdata = rd ? word : '0;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> ($stable(field_q) && $stable(sa_q) && $stable(a_q)));
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> (field_q == $past(field) && a_q == $past(on_a)));
    a_r5_sys_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (a_q && !sa_q && field_q == '0));
endmodule

// File: rtl/hreg_if.sv
// Top of the host register interface: decode, control register and
// system word. Assumes host strobes are already synchronous to clk.
module hreg_if
    import hreg_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int SYS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs_n,
    input  logic               host_ctl_n,
    input  logic               host_rd_wr,
    input  logic               host_a0,
    input  logic [CTRL_W-1:0]  host_wdata,
    output logic [SYS_W-1:0]   host_rdata,
    output logic               host_rdata_oe,
    input  logic               cmd_capture,
    input  logic [FIELD_W-1:0] cmd_field,
    input  logic               cmd_is_subaddr,
    input  logic               cmd_on_a,
    output logic               master_rst_pulse,
    output logic               ch_a_en,
    output logic               ch_b_en,
    output logic               term_flag,
    output logic               sys_busy,
    output logic               subsys_busy,
    output logic               selftest_sel_a,
    output logic               selftest_en,
    output logic               svc_req,
    output logic [FLAG_W-1:0]  stword_flags
);
    logic  wr_ctrl;
    logic  rd_sys;
    logic  clr;
    ctrl_t ctrl_q;

    hreg_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (host_cs_n),
        .ctl_n      (host_ctl_n),
        .rd_wr      (host_rd_wr),
        .a0         (host_a0),
        .wr_ctrl    (wr_ctrl),
        .rd_sys     (rd_sys),
        .clr        (clr),
        .mrst_pulse (master_rst_pulse)
    );

    hreg_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctrl),
        .clr   (clr),
        .wdata (host_wdata),
        .cap   (cmd_capture),
        .q     (ctrl_q),
        .snap  (stword_flags)
    );

    hreg_sys #(.FIELD_W(FIELD_W), .SYS_W(SYS_W)) u_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .upd   (cmd_capture),
        .field (cmd_field),
        .is_sa (cmd_is_subaddr),
        .on_a  (cmd_on_a),
        .rd    (rd_sys),
        .rdata (host_rdata),
        .oe    (host_rdata_oe)
    );

    // Fan the control register out to named outputs.
    always_comb begin
        ch_a_en        = ctrl_q.cha_en;
        ch_b_en        = ctrl_q.chb_en;
        term_flag      = ctrl_q.term_flag;
        sys_busy       = ctrl_q.sys_busy;
        subsys_busy    = ctrl_q.subsys_busy;
        selftest_sel_a = ctrl_q.st_sel_a;
        selftest_en    = ctrl_q.st_en;
        svc_req        = ctrl_q.svc_req;
    end

    a_r6_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata_oe |-> !master_rst_pulse || !$past(host_rdata_oe));
endmodule

// File: tb/hreg_if_test.sv
module hreg_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ctl_n = 1'b1, rw = 1'b1, a0 = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] rdata;
    logic        oe;
    logic        cap = 1'b0;
    logic [4:0]  fld = '0;
    logic        is_sa = 1'b0, on_a = 1'b0;
    logic        pulse;
    logic        o_cha, o_chb, o_tf, o_busy, o_ssb, o_sel, o_sten, o_srq;
    logic [3:0]  flags;

    int nchk = 0;
    int nfail = 0;

    // Reference state
    logic [7:0] m_ctrl;
    logic [4:0] m_fld;
    logic       m_sa, m_a, m_prev, m_pulse;
    logic [3:0] m_snap;

    always #2 clk = ~clk;

    hreg_if uut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_ctl_n(ctl_n),
        .host_rd_wr(rw), .host_a0(a0), .host_wdata(wdata),
        .host_rdata(rdata), .host_rdata_oe(oe), .cmd_capture(cap),
        .cmd_field(fld), .cmd_is_subaddr(is_sa), .cmd_on_a(on_a),
        .master_rst_pulse(pulse), .ch_a_en(o_cha), .ch_b_en(o_chb),
        .term_flag(o_tf), .sys_busy(o_busy), .subsys_busy(o_ssb),
        .selftest_sel_a(o_sel), .selftest_en(o_sten), .svc_req(o_srq),
        .stword_flags(flags)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] sysword();
        return {9'b0, m_a, m_sa, m_fld};
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_snap = '0; m_fld = '0; m_sa = 1'b0; m_a = 1'b1;
    endtask

    task automatic check_regs(input string tag);
        chk(tag, {8'b0, o_srq, o_sten, o_sel, o_ssb, o_busy, o_tf, o_chb, o_cha}, {8'b0, m_ctrl});
        chk("R10 flags", {12'b0, flags}, {12'b0, m_snap});
        chk("R4 pulse", {15'b0, pulse}, {15'b0, m_pulse});
    endtask

    // One cycle: drive, check read path, clock, update model, check registers.
    task automatic cycle(input logic c, input logic t, input logic r, input logic a,
                         input logic [7:0] d, input logic u, input logic [4:0] f,
                         input logic s, input logic ch);
        logic exp_oe, wr_any, clr;
        logic [7:0] old;
        cs_n = c; ctl_n = t; rw = r; a0 = a; wdata = d;
        cap = u; fld = f; is_sa = s; on_a = ch;
        #1;
        exp_oe = !c && !t && r && !a;
        chk(exp_oe ? "R6 oe" : "R3 oe", {15'b0, oe}, {15'b0, exp_oe});
        chk(exp_oe ? "R7 rdata" : "R6 rdata", rdata, exp_oe ? sysword() : 16'h0);
        @(posedge clk); #1;
        wr_any = !c && !t && !r;
        clr = wr_any && a && !m_prev;
        old = m_ctrl;
        if (clr) model_reset();
        else begin
            if (u) begin
                m_snap = {old[7], old[4], old[3], old[2]};
                m_fld = f; m_sa = s; m_a = ch;
            end
            if (wr_any && !a) m_ctrl = d;
        end
        m_prev = wr_any && a;
        m_pulse = clr;
        check_regs(clr ? "R5 ctrl" : "R1 ctrl");
    endtask

    task automatic idle();
        cycle(1, 1, 1, 0, 8'h00, 0, 5'h00, 0, 0);
    endtask

    task automatic rd_check(input string tag);
        cycle(0, 0, 1, 0, 8'h5A, 0, 5'h1F, 1, 0);
        chk(tag, sysword(), sysword());
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        model_reset();
        m_prev = 1'b0; m_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check_regs("R9 reset ctrl");
        rst_n = 1'b1;
        cs_n = 0; ctl_n = 0; rw = 1; a0 = 0;
        #1;
        chk("R9 reset word", rdata, 16'h0040);
        chk("R9 oe", {15'b0, oe}, 16'h1);
        @(posedge clk); #1;

        // R2 all control values, each bit position
        for (int v = 0; v < 256; v++) begin
            cycle(0, 0, 0, 0, v[7:0], 0, 5'h00, 0, 0);
        end
        chk("R2 bit7 svc_req", {15'b0, o_srq}, 16'h1);

        // R3 / R4 sweep of all strobe combinations
        for (int k = 0; k < 16; k++) begin
            cycle(0, 0, 0, 0, 8'hC3 ^ k[7:0], 0, 5'h00, 0, 0);
            cycle(0, 0, 0, 0, 8'hC3 ^ k[7:0], 1, 5'h0A, 1, 0);
            cycle(k[3], k[2], k[1], k[0], 8'h3C + k[7:0], 0, 5'h00, 0, 0);
            idle();
            rd_check("R7 after sweep");
        end

        // R8 capture every field/type/channel combination
        for (int k = 0; k < 128; k++) begin
            cycle(1, 1, 1, 0, 8'h00, 1, k[4:0], k[5], k[6]);
            cycle(1, 1, 0, 0, 8'hFF, 0, ~k[4:0], ~k[5], ~k[6]);
            rd_check("R8 captured word");
        end

        // R10 snapshot timing: earlier write included, same-edge write not
        for (int k = 0; k < 16; k++) begin
            cycle(0, 0, 0, 0, {k[3], 2'b00, k[2], k[1], k[0], 2'b11}, 0, 5'h00, 0, 0);
            cycle(1, 1, 1, 0, 8'h00, 1, 5'h01, 0, 1);
            chk("R10 earlier write", {12'b0, flags}, {12'b0, k[3:0]});
            cycle(0, 0, 0, 0, ~{k[3], 2'b00, k[2], k[1], k[0], 2'b11}, 1, 5'h02, 1, 1);
            chk("R10 same-edge write", {12'b0, flags}, {12'b0, k[3:0]});
        end

        // R4 / R5 held reset write with simultaneous capture
        cycle(0, 0, 0, 0, 8'hFF, 1, 5'h15, 1, 0);
        cycle(1, 1, 1, 0, 8'h00, 1, 5'h15, 1, 0);
        for (int k = 0; k < 3; k++) begin
            cycle(0, 0, 0, 1, 8'hFF, 1, 5'h0E, 1, 0);
        end
        idle();
        rd_check("R5 word after reset");
        cycle(0, 0, 0, 1, 8'hAA, 0, 5'h00, 0, 0);
        chk("R4 pulse after release", {15'b0, pulse}, 16'h1);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule